// File: doc/BRIEF.md
# E3 Far-End Failure Status Filter

This block takes the far-end receive failure (FERF) bit that an upstream framer pulls out of the maintenance byte of each incoming E3 frame. It turns that bit into a filtered status bit. The status follows the raw bit only after the raw bit has kept the same new value for a run of consecutive frames. The run length is 3 or 5 frames, picked by a configuration input. This stops a single corrupted frame from flipping the alarm.

Each change of the filtered status sets a sticky interrupt flag. This happens both when the alarm is declared and when it clears. The flag stays set until a read-clear pulse arrives. The interrupt request output is the flag gated by an enable input.

Frames count only while the framer reports frame synchronisation. Strobes that arrive while synchronisation is missing are dropped, and the run count is left as it was.

Top module: `e3_ferf_filter`

## Requirements
- R1: After reset, `ferf_status`, `irq_flag` and `irq_req` are all 0.
- R2: With `persist_sel`=0, `ferf_status` becomes 1 in the cycle after the 3rd consecutive accepted frame carrying `ferf_bit`=1, and not earlier.
- R3: With `persist_sel`=0 and `ferf_status`=1, the status returns to 0 after the 3rd consecutive accepted frame with `ferf_bit`=0, and not earlier.
- R4: With `persist_sel`=1, the required run is 5 consecutive accepted frames, for both declaring and clearing.
- R5: An accepted frame whose `ferf_bit` differs from the previous accepted frame restarts the run at one.
- R6: Every change of `ferf_status` sets `irq_flag` in the same cycle as the change.
- R7: `irq_flag` stays set until an `irq_clr` pulse arrives. After the pulse it reads 0, unless a status change happens in that same cycle, in which case the set wins.
- R8: `irq_req` is 1 exactly when `irq_flag` and `irq_en` are both 1.
- R9: A frame strobe while `frame_sync`=0 is ignored. It changes neither the status nor the run count.
- R10: Frames whose `ferf_bit` equals the current status never change the status and never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse, one per received frame |
| ferf_bit | input | 1 | FERF bit of that frame, valid with `frame_stb` |
| frame_sync | input | 1 | 1 while the framer is in frame alignment |
| persist_sel | input | 1 | 0: run of 3 frames, 1: run of 5 frames |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Read-clear pulse for the sticky flag |
| ferf_status | output | 1 | Filtered FERF status |
| irq_flag | output | 1 | Sticky change-of-status flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- `ferf_bit` matters only in cycles where `frame_stb` is high.
- `persist_sel` is held steady for the duration of a run.
- `irq_clr` is a one-cycle pulse.

The directed stimulus respects all three. It changes `persist_sel` only right after a reset, drives every strobe and clear for exactly one cycle, and sets all inputs on the falling edge so that each rising edge sees stable values.

// File: rtl/e3_ferf_pkg.sv
package e3_ferf_pkg;

    // One accepted frame event handed from the front end to the filter
    typedef struct packed {
        logic adv;   // frame counts toward the run
        logic smp;   // sampled FERF value of that frame
    } frame_evt_t;

    typedef enum logic {
        PERSIST_SHORT = 1'b0,
        PERSIST_LONG  = 1'b1
    } persist_t;

    function automatic int unsigned persist_limit(
        input persist_t sel,
        input int unsigned short_n,
        input int unsigned long_n
    );
        return (sel == PERSIST_LONG) ? long_n : short_n;
    endfunction

endpackage

// File: rtl/ferf_run_counter.sv
module ferf_run_counter
    import e3_ferf_pkg::*;
#(
    parameter int unsigned RUN_MAX = 5,
    localparam int unsigned RW = $clog2(RUN_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  frame_evt_t    evt,
    output logic [RW-1:0] streak
);
    logic [RW-1:0] run_q;
    logic          last_q;

    // Length of the current run, counting the frame arriving now
    always_comb begin
        if (!evt.adv)
            streak = run_q;
        else if (evt.smp != last_q)
            streak = RW'(1);
        else if (run_q == RW'(RUN_MAX))
            streak = run_q;
        else
            streak = run_q + RW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            last_q <= 1'b0;
        end else if (evt.adv) begin
            run_q  <= streak;
            last_q <= evt.smp;
        end
    end
endmodule

// File: rtl/ferf_status_reg.sv
module ferf_status_reg
    import e3_ferf_pkg::*;
#(
    parameter int unsigned SHORT_N = 3,
    parameter int unsigned LONG_N  = 5,
    localparam int unsigned RW = $clog2(LONG_N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  frame_evt_t    evt,
    input  logic [RW-1:0] streak,
    input  persist_t      sel,
    output logic          status,
    output logic          flip
);
    logic [RW-1:0] limit;

    always_comb begin
        limit = RW'(persist_limit(sel, SHORT_N, LONG_N));
        flip  = evt.adv && (evt.smp != status) && (streak >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst)
            status <= 1'b0;
        else if (flip)
            status <= evt.smp;
    end
endmodule

// File: rtl/ferf_irq_latch.sv
module ferf_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic flag,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    assign req = flag & en;
endmodule

// File: rtl/e3_ferf_filter.sv
module e3_ferf_filter
    import e3_ferf_pkg::*;
#(
    parameter int unsigned SHORT_N = 3,
    parameter int unsigned LONG_N  = 5,
    localparam int unsigned RW = $clog2(LONG_N + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_stb,
    input  logic ferf_bit,
    input  logic frame_sync,
    input  logic persist_sel,
    input  logic irq_en,
    input  logic irq_clr,
    output logic ferf_status,
    output logic irq_flag,
    output logic irq_req
);
    frame_evt_t    evt;
    logic [RW-1:0] streak;
    logic          flip;

    always_comb begin
        evt.adv = frame_stb && frame_sync;
        evt.smp = ferf_bit;
    end

    ferf_run_counter #(.RUN_MAX(LONG_N)) u_run (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .streak (streak)
    );

    ferf_status_reg #(.SHORT_N(SHORT_N), .LONG_N(LONG_N)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .streak (streak),
        .sel    (persist_t'(persist_sel)),
        .status (ferf_status),
        .flip   (flip)
    );

    ferf_irq_latch u_irq (
        .clk  (clk),
        .rst  (rst),
        .set  (flip),
        .clr  (irq_clr),
        .en   (irq_en),
        .flag (irq_flag),
        .req  (irq_req)
    );
endmodule

// File: rtl/e3_ferf_filter_chk.sv
module e3_ferf_filter_chk (
    input logic clk,
    input logic rst,
    input logic frame_stb,
    input logic ferf_bit,
    input logic frame_sync,
    input logic irq_en,
    input logic irq_clr,
    input logic ferf_status,
    input logic irq_flag,
    input logic irq_req
);
    // R9
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(frame_stb && frame_sync) |=> (ferf_status == $past(ferf_status)));

    // R6
    flag_on_change_chk: assert property (@(posedge clk) disable iff (rst)
        (ferf_status != $past(ferf_status)) |-> irq_flag);

    // R10
    change_follows_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (ferf_status != $past(ferf_status)) |-> (ferf_status == $past(ferf_bit)));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R7
    flag_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        irq_clr |=> (!irq_flag || (ferf_status != $past(ferf_status))));

    // R8
    req_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_flag || !irq_en) |-> !irq_req);
endmodule

bind e3_ferf_filter e3_ferf_filter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_stb   (frame_stb),
    .ferf_bit    (ferf_bit),
    .frame_sync  (frame_sync),
    .irq_en      (irq_en),
    .irq_clr     (irq_clr),
    .ferf_status (ferf_status),
    .irq_flag    (irq_flag),
    .irq_req     (irq_req)
);

// File: tb/sim_e3_ferf_filter.sv
module sim_e3_ferf_filter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_stb = 1'b0, ferf_bit = 1'b0, frame_sync = 1'b1;
    logic persist_sel = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
    logic ferf_status, irq_flag, irq_req;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    e3_ferf_filter u0 (.*);

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset(logic sel);
        @(negedge clk);
        rst = 1'b1; persist_sel = sel; frame_sync = 1'b1;
        irq_en = 1'b0; irq_clr = 1'b0; frame_stb = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive one frame on the falling edge; results are visible at the next falling edge
    task automatic frame(logic v, logic clr = 1'b0);
        frame_stb = 1'b1; ferf_bit = v; irq_clr = clr;
        @(negedge clk);
        frame_stb = 1'b0; irq_clr = 1'b0;
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        check("R1 status", ferf_status, 1'b0);
        check("R1 flag", irq_flag, 1'b0);
        check("R1 req", irq_req, 1'b0);
    endtask

    task automatic t_short();
        do_reset(1'b0);
        frame(1); frame(1);
        check("R2 early", ferf_status, 1'b0);
        frame(1);
        check("R2 declared", ferf_status, 1'b1);
        check("R6 flag on declare", irq_flag, 1'b1);
        irq_en = 1'b1; #1;
        check("R8 req enabled", irq_req, 1'b1);
        irq_en = 1'b0; #1;
        check("R8 req masked", irq_req, 1'b0);
        irq_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 sticky", irq_flag, 1'b1);
        pulse_clr();
        check("R7 cleared", irq_flag, 1'b0);
        check("R8 req after clear", irq_req, 1'b0);
        frame(0); frame(0);
        check("R3 early", ferf_status, 1'b1);
        frame(0);
        check("R3 cleared", ferf_status, 1'b0);
        check("R6 flag on clear", irq_flag, 1'b1);
    endtask

    task automatic t_long();
        do_reset(1'b1);
        repeat (4) frame(1);
        check("R4 declare early", ferf_status, 1'b0);
        frame(1);
        check("R4 declare", ferf_status, 1'b1);
        repeat (4) frame(0);
        check("R4 clear early", ferf_status, 1'b1);
        frame(0);
        check("R4 clear", ferf_status, 1'b0);
    endtask

    task automatic t_restart();
        do_reset(1'b0);
        frame(1); frame(1); frame(0); frame(1); frame(1);
        check("R5 restarted", ferf_status, 1'b0);
        frame(1);
        check("R5 after full run", ferf_status, 1'b1);
    endtask

    task automatic t_nosync();
        do_reset(1'b0);
        frame_sync = 1'b0;
        repeat (5) frame(1);
        check("R9 status ignored", ferf_status, 1'b0);
        check("R9 flag ignored", irq_flag, 1'b0);
        frame_sync = 1'b1;
        frame(1); frame(1);
        frame_sync = 1'b0;
        repeat (3) frame(0);
        frame_sync = 1'b1;
        frame(1);
        check("R9 count held", ferf_status, 1'b1);
    endtask

    task automatic t_same();
        do_reset(1'b0);
        repeat (6) frame(0);
        check("R10 status", ferf_status, 1'b0);
        check("R10 flag", irq_flag, 1'b0);
    endtask

    task automatic t_collide();
        do_reset(1'b0);
        frame(1); frame(1);
        frame(1, 1'b1);
        check("R7 set beats clear", irq_flag, 1'b1);
    endtask

    initial begin
        t_reset();
        t_short();
        t_long();
        t_restart();
        t_nosync();
        t_same();
        t_collide();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule